// File: doc/BRIEF.md
# Carry-Pipelined Segmented Adder

This block adds two wide operands without ever forming one long carry chain. Each operand is cut into slices of a fixed width. Each slice is added in its own pipeline stage, and the carry out of a slice is registered before the next stage uses it. The slowest path therefore depends on the slice width, not on the full word width. The result is one bit wider than the operands.

Operands of higher significance wait in input skew registers until their stage is reached. Lower result slices wait in output deskew registers, so that every slice of a sum leaves in the same cycle. The latency is the number of slices. A parent structure, such as a reduction tree, can compute it when it is elaborated and size its own delay lines to match.

The block accepts a new operand pair on every cycle. A mode parameter selects unsigned or two's-complement operands. The block is built from general logic and flip-flops only.

Top module: `seg_adder`

## Requirements
- R1: In unsigned mode, `sum` equals `op_a + op_b` taken over WIDTH+1 bits. Bit WIDTH of `sum` holds the final carry.
- R2: In signed mode, `op_a` and `op_b` are two's-complement values. `sum` is their exact signed total over WIDTH+1 bits, and bit WIDTH of `sum` is the sign of that total.
- R3: A pair presented with `in_valid` high on one rising edge appears on `sum` with `out_valid` high exactly ceil(WIDTH/CHUNK) rising edges later, counting the edge that samples it. `out_valid` is never high without such a pair.
- R4: A new pair can be presented on every cycle. Back-to-back pairs give back-to-back results in the same order, and at most ceil(WIDTH/CHUNK) pairs are in flight at any time.
- R5: A carry moves correctly across every slice boundary. For example, all-ones plus one gives 2^WIDTH.
- R6: When WIDTH is not a multiple of CHUNK, the top slice is narrower than the others. The latency is still ceil(WIDTH/CHUNK), and the results remain exact.
- R7: A synchronous active-high `rst` clears `out_valid` and `sum` on the next edge and drops all pairs in flight. No pair accepted before the reset produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `op_a`/`op_b` as a pair to add |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Marks `sum` as a result |
| sum | output | WIDTH+1 | Sum of the pair accepted LATENCY edges earlier |

## Verification
Two things happen in the same cycle in this block. First, a stage takes a registered carry from the slice below while the stage below is already taking the next pair. Second, a result leaves the block while a new pair enters it. Both are provoked with long bursts of pairs on consecutive cycles that mix random values with carry-ripple cases such as all-ones plus one. Each result is judged against a scoreboard entry that holds the exact expected sum and the exact cycle on which it must appear. A carry taken from a neighbouring pair, or a result that comes out of order, therefore shows up as a wrong value or a wrong cycle.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;

    typedef enum logic {
        ARITH_UNSIGNED = 1'b0,
        ARITH_SIGNED   = 1'b1
    } arith_mode_e;

    // number of slices a word of w bits is cut into
    function automatic int chunk_count(input int w, input int c);
        return (w + c - 1) / c;
    endfunction

    // width of slice k; the top slice may be narrower
    function automatic int chunk_width(input int w, input int c, input int k);
        int hi;
        hi = (k + 1) * c;
        if (hi > w) hi = w;
        return hi - k * c;
    endfunction

    // bits needed to count 0..n
    function automatic int count_bits(input int n);
        int b;
        b = 1;
        while ((1 << b) <= n) b++;
        return b;
    endfunction

endpackage

// File: rtl/seg_skew_line.sv
module seg_skew_line #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout = pipe_q[DEPTH-1];

    // R7: reset empties the line
    a_r7_skew_flush: assert property (@(posedge clk) rst |=> dout == '0);

endmodule

// File: rtl/seg_chunk_stage.sv
module seg_chunk_stage #(
    parameter int CW     = 8,
    parameter bit EXTEND = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] op_a,
    input  logic [CW-1:0] op_b,
    input  logic          cin,
    output logic [CW:0]   res_q
);

    logic          ext_a;
    logic          ext_b;
    logic [CW:0]   sum_d;

    // only the top slice in signed mode widens by sign; others widen by zero
    assign ext_a = EXTEND ? op_a[CW-1] : 1'b0;
    assign ext_b = EXTEND ? op_b[CW-1] : 1'b0;
    assign sum_d = {ext_a, op_a} + {ext_b, op_b} + {{CW{1'b0}}, cin};

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= sum_d;
    end

    // R1: the low result bit is the parity of the inputs one edge earlier
    a_r1_slice_parity: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> res_q[0] == $past(op_a[0] ^ op_b[0] ^ cin));

    // R7: reset clears the slice register
    a_r7_slice_clear: assert property (@(posedge clk) rst |=> res_q == '0);

endmodule

// File: rtl/seg_adder.sv
module seg_adder
    import seg_add_pkg::*;
#(
    parameter int          WIDTH = 32,
    parameter int          CHUNK = 8,
    parameter arith_mode_e MODE  = ARITH_UNSIGNED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             out_valid,
    output logic [WIDTH:0]   sum
);

    localparam int NCHUNK  = chunk_count(WIDTH, CHUNK);
    localparam int LATENCY = NCHUNK;
    localparam int CNT_W   = count_bits(LATENCY + 1);

    logic [NCHUNK-1:0] carry;

    for (genvar k = 0; k < NCHUNK; k++) begin : g_slice
        localparam int LO  = k * CHUNK;
        localparam int CW  = chunk_width(WIDTH, CHUNK, k);
        localparam bit TOP = (k == NCHUNK - 1);

        logic [CW-1:0] a_sk;
        logic [CW-1:0] b_sk;
        logic          cin;
        logic [CW:0]   res;

        if (k == 0) begin : g_first
            assign a_sk = op_a[LO +: CW];
            assign b_sk = op_b[LO +: CW];
            assign cin  = 1'b0;
        end else begin : g_later
            logic [2*CW-1:0] ab_sk;
            seg_skew_line #(.WIDTH(2 * CW), .DEPTH(k)) u_skew (
                .clk  (clk),
                .rst  (rst),
                .din  ({op_a[LO +: CW], op_b[LO +: CW]}),
                .dout (ab_sk)
            );
            assign a_sk = ab_sk[2*CW-1:CW];
            assign b_sk = ab_sk[CW-1:0];
            assign cin  = carry[k-1];
        end

        seg_chunk_stage #(
            .CW     (CW),
            .EXTEND (TOP && (MODE == ARITH_SIGNED))
        ) u_stage (
            .clk   (clk),
            .rst   (rst),
            .op_a  (a_sk),
            .op_b  (b_sk),
            .cin   (cin),
            .res_q (res)
        );

        assign carry[k] = res[CW];

        if (TOP) begin : g_top_out
            assign sum[WIDTH:LO] = res;
        end else begin : g_deskew
            seg_skew_line #(.WIDTH(CW), .DEPTH(NCHUNK - 1 - k)) u_deskew (
                .clk  (clk),
                .rst  (rst),
                .din  (res[CW-1:0]),
                .dout (sum[LO +: CW])
            );
        end
    end

    seg_skew_line #(.WIDTH(1), .DEPTH(LATENCY)) u_valid_line (
        .clk  (clk),
        .rst  (rst),
        .din  (in_valid),
        .dout (out_valid)
    );

    // pairs accepted and not yet delivered; guards the assertions below
    logic [CNT_W-1:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) inflight_q <= '0;
        else     inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R7: reset leaves no result on the outputs
    a_r7_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && sum == '0));

    // R3: every valid result belongs to an accepted pair
    a_r3_no_orphan_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> inflight_q != '0);

    // R4: no more pairs in flight than pipeline stages
    a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= CNT_W'(LATENCY));

endmodule

// File: tb/seg_adder_tb_top.sv
module seg_adder_tb_top;
    import seg_add_pkg::*;

    localparam int UW = 32, UC = 8, UN = 4;
    localparam int SW = 20, SC = 8, SN = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          u_iv, u_ov, s_iv, s_ov;
    logic [UW-1:0] u_a, u_b;
    logic [UW:0]   u_sum;
    logic [SW-1:0] s_a, s_b;
    logic [SW:0]   s_sum;

    seg_adder #(.WIDTH(UW), .CHUNK(UC), .MODE(ARITH_UNSIGNED)) dut_i (
        .clk(clk), .rst(rst), .in_valid(u_iv), .op_a(u_a), .op_b(u_b),
        .out_valid(u_ov), .sum(u_sum));

    seg_adder #(.WIDTH(SW), .CHUNK(SC), .MODE(ARITH_SIGNED)) dut2_i (
        .clk(clk), .rst(rst), .in_valid(s_iv), .op_a(s_a), .op_b(s_b),
        .out_valid(s_ov), .sum(s_sum));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit timeout = 1'b0;

    logic [UW:0] uq_sum[$];
    int          uq_cyc[$];
    string       uq_tag[$];
    logic [SW:0] sq_sum[$];
    int          sq_cyc[$];

    task automatic check(input bit ok, input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %h exp %h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // driver: one cycle of stimulus on both adders, expectations queued
    task automatic drive(input logic uv, input logic [UW-1:0] ua, input logic [UW-1:0] ub,
                         input string tag,
                         input logic sv, input logic [SW-1:0] sa, input logic [SW-1:0] sb);
        @(negedge clk);
        u_iv = uv; u_a = ua; u_b = ub;
        s_iv = sv; s_a = sa; s_b = sb;
        if (uv) begin
            uq_sum.push_back({1'b0, ua} + {1'b0, ub});
            uq_cyc.push_back(cyc + UN);
            uq_tag.push_back(tag);
        end
        if (sv) begin
            sq_sum.push_back({sa[SW-1], sa} + {sb[SW-1], sb});
            sq_cyc.push_back(cyc + SN);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, "", 1'b0, '0, '0);
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (u_ov) begin
                if (uq_sum.size() == 0) begin
                    check(1'b0, "R3 unsigned orphan result", 64'(u_sum), 64'd0);
                end else begin
                    logic [UW:0] e;
                    int ec;
                    string t;
                    e = uq_sum.pop_front(); ec = uq_cyc.pop_front(); t = uq_tag.pop_front();
                    check(u_sum == e, t, 64'(u_sum), 64'(e));
                    check(cyc == ec, "R3 unsigned latency", 64'(cyc), 64'(ec));
                end
            end
            if (s_ov) begin
                if (sq_sum.size() == 0) begin
                    check(1'b0, "R2 signed orphan result", 64'(s_sum), 64'd0);
                end else begin
                    logic [SW:0] e;
                    int ec;
                    e = sq_sum.pop_front(); ec = sq_cyc.pop_front();
                    check(s_sum == e, "R2 signed sum", 64'(s_sum), 64'(e));
                    check(cyc == ec, "R6 narrow top slice latency", 64'(cyc), 64'(ec));
                end
            end
        end
    end

    initial begin
        rst = 1'b1; u_iv = 1'b0; s_iv = 1'b0;
        u_a = '0; u_b = '0; s_a = '0; s_b = '0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                check(!u_ov && u_sum == '0, "R7 reset state unsigned", 64'(u_sum), 64'd0);
                check(!s_ov && s_sum == '0, "R7 reset state signed", 64'(s_sum), 64'd0);

                // R5 carry ripple across all slice boundaries
                drive(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, "R5 all ones plus one",
                      1'b1, 20'hFFFFF, 20'h00001);
                drive(1'b1, 32'h0000_00FF, 32'h0000_0001, "R5 first boundary",
                      1'b1, 20'h80000, 20'h80000);
                drive(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 max plus max",
                      1'b1, 20'h7FFFF, 20'h7FFFF);
                drive(1'b1, 32'h00FF_FF00, 32'h0000_0100, "R5 middle ripple",
                      1'b1, 20'h7FFFF, 20'h00001);
                drive(1'b1, 32'h0, 32'h0, "R1 zero plus zero",
                      1'b1, 20'h0, 20'hFFFFF);
                idle(2);

                // R4 long back-to-back burst of random pairs
                for (int i = 0; i < 40; i++)
                    drive(1'b1, $urandom, $urandom, "R4 burst",
                          1'b1, SW'($urandom), SW'($urandom));

                // R1 sparse traffic with gaps
                for (int i = 0; i < 30; i++) begin
                    drive(1'b1, $urandom, $urandom, "R1 sparse",
                          (i % 2) == 0, SW'($urandom), SW'($urandom));
                    if (i % 3 == 0) idle(1 + i % 4);
                end
                idle(UN + 2);
                check(uq_sum.size() == 0, "R4 unsigned all delivered", 64'(uq_sum.size()), 64'd0);
                check(sq_sum.size() == 0, "R4 signed all delivered", 64'(sq_sum.size()), 64'd0);

                // R7 reset while pairs are in flight
                for (int i = 0; i < 3; i++)
                    drive(1'b1, $urandom, $urandom, "R7 dropped", 1'b1, SW'($urandom), SW'($urandom));
                @(negedge clk);
                rst = 1'b1; u_iv = 1'b0; s_iv = 1'b0;
                @(negedge clk);
                @(negedge clk);
                uq_sum.delete(); uq_cyc.delete(); uq_tag.delete();
                sq_sum.delete(); sq_cyc.delete();
                rst = 1'b0;
                for (int i = 0; i < UN + 2; i++) begin
                    @(negedge clk);
                    check(!u_ov && !s_ov, "R7 no result after reset",
                          64'({u_ov, s_ov}), 64'd0);
                end

                // traffic resumes cleanly after reset
                drive(1'b1, 32'h8000_0000, 32'h8000_0000, "R1 top carry out",
                      1'b1, 20'h80000, 20'h7FFFF);
                idle(UN + 2);
                check(uq_sum.size() == 0 && sq_sum.size() == 0, "R4 drained after reset",
                      64'(uq_sum.size() + sq_sum.size()), 64'd0);
            end
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule